// File: doc/BRIEF.md
# Floating-Point Format Converter

This block re-encodes a floating-point value from one custom format into another. Each side is described by its own exponent width, fraction width and exponent bias. It sits where a datapath built for one precision hands data to a region built for another, and it works in both directions: narrowing to fewer bits or widening to more.

A source word arrives with a valid strobe. The source is always read with IEEE-style rules: a sign bit, zeros, subnormals, infinities and NaNs. The word is first sorted into one of five classes: zero, subnormal, normal, infinite or not-a-number. A subnormal is normalised at this stage. The value is then re-biased and re-encoded under the policies chosen for the destination:

- rounding: nearest-even or truncation;
- out-of-range results: IEEE, saturating or unchecked;
- subnormal support: on or off;
- sign: a dynamic sign bit, or a fixed sign with no bit stored.

The result is registered. One conversion is accepted every cycle.

The class names `CLS_ZERO`, `CLS_SUBNORMAL`, `CLS_NORMAL`, `CLS_INFINITE` and `CLS_NAN` pick the encoding path through a single case statement. Only one state element exists: the output register, which moves from idle to holding a result each time a valid word arrives.

Top module: `fpconv_unit`

## Requirements
- R1: Word layout is fraction in the low bits, exponent directly above it, and sign (when present) in the MSB. A finite source is re-biased as exponent field minus source bias plus destination bias. A wider destination fraction gets zeros appended on the right. A source zero gives an all-zero magnitude that keeps its sign.
- R2: In nearest-even mode, dropped fraction bits round to the closest encodable value. Exact ties go to an even last fraction bit.
- R3: In truncate mode, dropped fraction bits are discarded without any increment.
- R4: A rounding increment that carries out of the fraction adds one to the exponent field and leaves a zero fraction.
- R5: In IEEE exception mode, a biased result exponent that reaches all-ones, either directly or through a rounding carry, yields infinity: exponent all ones, fraction zero, sign kept.
- R6: In saturating mode, overflow, a source infinity and a source NaN all give the largest finite magnitude: exponent all ones minus one, fraction all ones. In unchecked mode, a source infinity or NaN gives the same word, and range overflow is not detected.
- R7: In IEEE exception mode, a source NaN gives a quiet NaN (exponent all ones, fraction MSB set, the rest clear) with the source sign. A source infinity gives an infinity of the same sign.
- R8: With destination subnormals enabled, a value below the smallest normal is encoded as a rounded subnormal. Depending on rounding, it may become the smallest normal or a signed zero.
- R9: With destination subnormals disabled, any value whose biased destination exponent is below one becomes zero, with no rounding up.
- R10: A source subnormal is normalised, so it converts to an exact normal when the destination range can hold it.
- R11: Under the dynamic sign policy, the output carries the source sign in its MSB. Under a fixed-sign policy, the output is exponent plus fraction only, and the source sign is dropped.
- R12: Reset clears `out_valid` and `out_bits`. `out_valid` follows `in_valid` one cycle later, one conversion per cycle. `out_bits` holds its value while no input is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source word present |
| in_bits | input | 1+SRC_EXP+SRC_FRAC | Source word: sign, exponent, fraction |
| out_valid | output | 1 | Converted word present |
| out_bits | output | DST_W | Destination word, with a sign bit only under the dynamic policy |

## Verification
Rounding and range handling can both act on one value in the same cycle. A fraction of all ones rounds up, and the carry moves the exponent. The bench places such a fraction just below the largest exponent, so the carry must turn into infinity. It places another just below the smallest normal, so a subnormal must round up into the first normal. Each outcome is compared against an encoding worked out by hand from the requirements, as is the round-to-even tie that lands on a signed zero.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    typedef enum logic {
        RND_NEAREST_EVEN,
        RND_TRUNCATE
    } rnd_e;

    typedef enum logic [1:0] {
        EXC_IEEE,
        EXC_SATURATE,
        EXC_UNCHECKED
    } exc_e;

    typedef enum logic [1:0] {
        SIGN_DYNAMIC,
        SIGN_POSITIVE,
        SIGN_NEGATIVE
    } sign_e;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUBNORMAL,
        CLS_NORMAL,
        CLS_INFINITE,
        CLS_NAN
    } cls_e;

endpackage

// File: rtl/fpc_unpack.sv
module fpc_unpack
    import fpc_pkg::*;
#(
    parameter int SRC_EXP  = 7,
    parameter int SRC_FRAC = 22,
    parameter int SRC_BIAS = 63,
    parameter int EXPW     = 16,
    localparam int SRC_W   = 1 + SRC_EXP + SRC_FRAC,
    localparam int PW      = $clog2(SRC_FRAC)
) (
    input  logic [SRC_W-1:0]       src,
    output cls_e                   cls,
    output logic                   sgn,
    output logic signed [EXPW-1:0] uexp,
    output logic [SRC_FRAC:0]      mant
);

    logic [SRC_EXP-1:0]  exp_f;
    logic [SRC_FRAC-1:0] frac_f;
    logic [PW-1:0]       top_pos;
    logic [PW:0]         lshift;

    assign sgn    = src[SRC_W-1];
    assign exp_f  = src[SRC_W-2 -: SRC_EXP];
    assign frac_f = src[SRC_FRAC-1:0];

    // position of the leading one in a subnormal fraction
    always_comb begin
        top_pos = '0;
        for (int i = 0; i < SRC_FRAC; i++) begin
            if (frac_f[i]) top_pos = PW'(i);
        end
        lshift = (PW+1)'(SRC_FRAC) - {1'b0, top_pos};
    end

    always_comb begin
        mant = {1'b1, frac_f};
        uexp = EXPW'(exp_f) - EXPW'(SRC_BIAS);
        if (exp_f == '1) begin
            cls = (frac_f != '0) ? CLS_NAN : CLS_INFINITE;
        end else if (exp_f == '0) begin
            cls  = (frac_f != '0) ? CLS_SUBNORMAL : CLS_ZERO;
            mant = {1'b0, frac_f} << lshift;
            uexp = EXPW'(1 - SRC_BIAS) - EXPW'(lshift);
        end else begin
            cls = CLS_NORMAL;
        end
    end

endmodule

// File: rtl/fpc_pack.sv
module fpc_pack
    import fpc_pkg::*;
#(
    parameter int    MW          = 23,
    parameter int    EXPW        = 16,
    parameter int    DST_EXP     = 6,
    parameter int    DST_FRAC    = 10,
    parameter int    DST_BIAS    = 31,
    parameter rnd_e  DST_RND     = RND_NEAREST_EVEN,
    parameter exc_e  DST_EXC     = EXC_IEEE,
    parameter bit    DST_SUBNORM = 1'b1,
    parameter sign_e DST_SIGN    = SIGN_DYNAMIC,
    localparam int   DST_W       = (DST_SIGN == SIGN_DYNAMIC ? 1 : 0) + DST_EXP + DST_FRAC
) (
    input  cls_e                   cls,
    input  logic                   sgn,
    input  logic signed [EXPW-1:0] uexp,
    input  logic [MW-1:0]          mant,
    output logic [DST_W-1:0]       dst
);

    localparam int L    = DST_FRAC + 1;
    localparam int WIDE = ((MW > L) ? MW : L) + 2;
    localparam int MAGW = DST_EXP + DST_FRAC;
    localparam int EMAX = (1 << DST_EXP) - 1;
    localparam logic [MAGW-1:0] INF    = {{DST_EXP{1'b1}}, {DST_FRAC{1'b0}}};
    localparam logic [MAGW-1:0] QNAN   = {{DST_EXP{1'b1}}, 1'b1, {(DST_FRAC-1){1'b0}}};
    localparam logic [MAGW-1:0] MAXFIN = {{(DST_EXP-1){1'b1}}, 1'b0, {DST_FRAC{1'b1}}};
    localparam logic [MAGW-1:0] OVFVAL = (DST_EXC == EXC_IEEE) ? INF : MAXFIN;

    logic signed [EXPW-1:0] be;
    logic [EXPW-1:0]        shv;
    logic [WIDE-1:0]        aligned, shifted;
    logic [L-1:0]           kept;
    logic                   is_norm, ovf_pre, ovf, lost, guard, sticky, rnd_up, flush;
    logic [DST_EXP-1:0]     expf;
    logic [MAGW:0]          mag_sum;
    logic [MAGW-1:0]        mag;
    logic                   unused_hidden;

    always_comb begin
        be      = uexp + EXPW'(DST_BIAS);
        is_norm = be > 0;
        ovf_pre = be >= EMAX;
        shv     = is_norm ? '0 : EXPW'(1) - be;
        aligned = {mant, {(WIDE-MW){1'b0}}};
        shifted = aligned >> shv;
        lost    = (shifted << shv) != aligned;
        kept    = shifted[WIDE-1 -: L];
        guard   = shifted[WIDE-1-L];
        sticky  = (|shifted[WIDE-2-L:0]) | lost;
        expf    = is_norm ? be[DST_EXP-1:0] : '0;
        rnd_up  = (DST_RND == RND_NEAREST_EVEN) && guard && (sticky || kept[0]);
        mag_sum = {1'b0, expf, kept[DST_FRAC-1:0]} + (MAGW+1)'(rnd_up);
        ovf     = ovf_pre || mag_sum[MAGW] || (mag_sum[MAGW-1 -: DST_EXP] == '1);
        flush   = !DST_SUBNORM && !is_norm;
    end

    assign unused_hidden = kept[L-1];

    always_comb begin
        mag = '0;
        unique case (cls)
            CLS_ZERO:     mag = '0;
            CLS_NAN:      mag = (DST_EXC == EXC_IEEE) ? QNAN : MAXFIN;
            CLS_INFINITE: mag = (DST_EXC == EXC_IEEE) ? INF : MAXFIN;
            CLS_NORMAL, CLS_SUBNORMAL: begin
                if (flush)                                mag = '0;
                else if (ovf && DST_EXC != EXC_UNCHECKED) mag = OVFVAL;
                else                                      mag = mag_sum[MAGW-1:0];
            end
            default:      mag = '0;
        endcase
    end

    generate
        if (DST_SIGN == SIGN_DYNAMIC) begin : g_dyn_sign
            assign dst = {sgn, mag};
        end else begin : g_fixed_sign
            logic unused_sign;
            assign unused_sign = sgn;
            assign dst = mag;
        end
    endgenerate

endmodule

// File: rtl/fpconv_unit.sv
module fpconv_unit
    import fpc_pkg::*;
#(
    parameter int    SRC_EXP     = 7,
    parameter int    SRC_FRAC    = 22,
    parameter int    SRC_BIAS    = 63,
    parameter int    DST_EXP     = 6,
    parameter int    DST_FRAC    = 10,
    parameter int    DST_BIAS    = 31,
    parameter rnd_e  DST_RND     = RND_NEAREST_EVEN,
    parameter exc_e  DST_EXC     = EXC_IEEE,
    parameter bit    DST_SUBNORM = 1'b1,
    parameter sign_e DST_SIGN    = SIGN_DYNAMIC,
    localparam int   SRC_W       = 1 + SRC_EXP + SRC_FRAC,
    localparam int   DST_W       = (DST_SIGN == SIGN_DYNAMIC ? 1 : 0) + DST_EXP + DST_FRAC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SRC_W-1:0] in_bits,
    output logic             out_valid,
    output logic [DST_W-1:0] out_bits
);

    localparam int EXPW = ((SRC_EXP > DST_EXP) ? SRC_EXP : DST_EXP) + $clog2(SRC_FRAC + 2) + 3;

    cls_e                   cls;
    logic                   sgn;
    logic signed [EXPW-1:0] uexp;
    logic [SRC_FRAC:0]      mant;
    logic [DST_W-1:0]       conv;

    fpc_unpack #(
        .SRC_EXP (SRC_EXP),
        .SRC_FRAC(SRC_FRAC),
        .SRC_BIAS(SRC_BIAS),
        .EXPW    (EXPW)
    ) u_unpack (
        .src (in_bits),
        .cls (cls),
        .sgn (sgn),
        .uexp(uexp),
        .mant(mant)
    );

    fpc_pack #(
        .MW         (SRC_FRAC + 1),
        .EXPW       (EXPW),
        .DST_EXP    (DST_EXP),
        .DST_FRAC   (DST_FRAC),
        .DST_BIAS   (DST_BIAS),
        .DST_RND    (DST_RND),
        .DST_EXC    (DST_EXC),
        .DST_SUBNORM(DST_SUBNORM),
        .DST_SIGN   (DST_SIGN)
    ) u_pack (
        .cls (cls),
        .sgn (sgn),
        .uexp(uexp),
        .mant(mant),
        .dst (conv)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bits  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_bits <= conv;
        end
    end

endmodule

// File: rtl/fpconv_unit_chk.sv
module fpconv_unit_chk
    import fpc_pkg::*;
#(
    parameter int    SRC_EXP     = 7,
    parameter int    SRC_FRAC    = 22,
    parameter int    SRC_BIAS    = 63,
    parameter int    DST_EXP     = 6,
    parameter int    DST_FRAC    = 10,
    parameter int    DST_BIAS    = 31,
    parameter rnd_e  DST_RND     = RND_NEAREST_EVEN,
    parameter exc_e  DST_EXC     = EXC_IEEE,
    parameter bit    DST_SUBNORM = 1'b1,
    parameter sign_e DST_SIGN    = SIGN_DYNAMIC,
    localparam int   SRC_W       = 1 + SRC_EXP + SRC_FRAC,
    localparam int   DST_W       = (DST_SIGN == SIGN_DYNAMIC ? 1 : 0) + DST_EXP + DST_FRAC
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [SRC_W-1:0] in_bits,
    input logic             out_valid,
    input logic [DST_W-1:0] out_bits
);

    logic [SRC_EXP-1:0]  s_exp;
    logic [SRC_FRAC-1:0] s_frac;
    logic [DST_EXP-1:0]  d_exp;
    logic [DST_FRAC-1:0] d_frac;

    assign s_exp  = in_bits[SRC_W-2 -: SRC_EXP];
    assign s_frac = in_bits[SRC_FRAC-1:0];
    assign d_exp  = out_bits[DST_EXP+DST_FRAC-1 -: DST_EXP];
    assign d_frac = out_bits[DST_FRAC-1:0];

    p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_bits));

    p_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && s_exp == '0 && s_frac == '0 |=> d_exp == '0 && d_frac == '0);

    generate
        if (DST_EXC == EXC_IEEE) begin : g_ieee
            p_qnan_r7: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid && s_exp == '1 && s_frac != '0 |=> d_exp == '1 && d_frac[DST_FRAC-1]);
        end
        if (DST_EXC == EXC_SATURATE) begin : g_sat
            p_no_inf_r6: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> d_exp != '1);
        end
        if (!DST_SUBNORM) begin : g_flush
            p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid && d_exp == '0 |-> d_frac == '0);
        end
    endgenerate

endmodule

bind fpconv_unit fpconv_unit_chk #(
    .SRC_EXP    (SRC_EXP),
    .SRC_FRAC   (SRC_FRAC),
    .SRC_BIAS   (SRC_BIAS),
    .DST_EXP    (DST_EXP),
    .DST_FRAC   (DST_FRAC),
    .DST_BIAS   (DST_BIAS),
    .DST_RND    (DST_RND),
    .DST_EXC    (DST_EXC),
    .DST_SUBNORM(DST_SUBNORM),
    .DST_SIGN   (DST_SIGN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_bits  (in_bits),
    .out_valid(out_valid),
    .out_bits (out_bits)
);

// File: tb/fpconv_unit_test.sv
module fpconv_unit_test;
    import fpc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        a_vld_i = 1'b0, b_vld_i = 1'b0, c_vld_i = 1'b0;
    logic [29:0] a_in = '0, c_in = '0;
    logic [16:0] b_in = '0;
    logic        a_vld_o, b_vld_o, c_vld_o;
    logic [16:0] a_out;
    logic [29:0] b_out;
    logic [15:0] c_out;

    // narrowing, nearest-even, IEEE exceptions, subnormals, dynamic sign
    fpconv_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(a_vld_i), .in_bits(a_in),
        .out_valid(a_vld_o), .out_bits(a_out));

    // widening back, unchecked exceptions
    fpconv_unit #(
        .SRC_EXP(6), .SRC_FRAC(10), .SRC_BIAS(31),
        .DST_EXP(7), .DST_FRAC(22), .DST_BIAS(63),
        .DST_EXC(EXC_UNCHECKED)
    ) uut_wide (
        .clk(clk), .rst_n(rst_n), .in_valid(b_vld_i), .in_bits(b_in),
        .out_valid(b_vld_o), .out_bits(b_out));

    // narrowing, truncation, saturation, no subnormals, positive-only
    fpconv_unit #(
        .DST_RND(RND_TRUNCATE), .DST_EXC(EXC_SATURATE),
        .DST_SUBNORM(1'b0), .DST_SIGN(SIGN_POSITIVE)
    ) uut_sat (
        .clk(clk), .rst_n(rst_n), .in_valid(c_vld_i), .in_bits(c_in),
        .out_valid(c_vld_o), .out_bits(c_out));

    typedef struct {
        int          which;
        logic [29:0] expv;
        string       tag;
    } item_t;

    item_t sb[$];
    int checks = 0;
    int errors = 0;
    logic [29:0] last_a = '0;

    function automatic logic [29:0] mk_n(input logic s, input logic [6:0] e, input logic [21:0] f);
        return {s, e, f};
    endfunction

    function automatic logic [29:0] mk_h(input logic s, input logic [5:0] e, input logic [9:0] f);
        return {13'd0, s, e, f};
    endfunction

    task automatic check(input string tag, input logic [29:0] act, input logic [29:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, expv);
        end
    endtask

    task automatic send(input int which, input logic [29:0] bits, input logic [29:0] expv, input string tag);
        item_t it;
        @(negedge clk);
        a_vld_i = (which == 0);
        b_vld_i = (which == 1);
        c_vld_i = (which == 2);
        a_in = bits;
        b_in = bits[16:0];
        c_in = bits;
        it.which = which;
        it.expv  = expv;
        it.tag   = tag;
        sb.push_back(it);
        if (which == 0) last_a = expv;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            a_vld_i = 1'b0;
            b_vld_i = 1'b0;
            c_vld_i = 1'b0;
        end
    endtask

    // monitor: compares each result against the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < 3; k++) begin
                logic        v;
                logic [29:0] act;
                item_t       it;
                v   = (k == 0) ? a_vld_o : (k == 1) ? b_vld_o : c_vld_o;
                act = (k == 0) ? {13'd0, a_out} : (k == 1) ? b_out : {14'd0, c_out};
                if (v) begin
                    if (sb.size() == 0) begin
                        checks++;
                        errors++;
                        $display("FAIL R12: unexpected output %h from instance %0d, expected none", act, k);
                    end else begin
                        it = sb.pop_front();
                        if (it.which != k) begin
                            checks++;
                            errors++;
                            $display("FAIL R12: result from instance %0d, expected instance %0d", k, it.which);
                        end else begin
                            check(it.tag, act, it.expv);
                        end
                    end
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R12 reset state
        check("R12 reset", {a_vld_o, b_vld_o, c_vld_o, a_out}, '0);
        check("R12 reset", b_out | {14'd0, c_out}, '0);
        rst_n = 1'b1;

        // instance A: 7/22 bias 63 -> 6/10 bias 31
        send(0, mk_n(0, 63, 0),                        30'h7C00,  "R1 rebias 1.0");
        send(0, mk_n(0, 63, 22'h1 << 21),              30'h7E00,  "R1 rebias 1.5");
        send(0, mk_n(1, 64, 0),                        30'h18000, "R11 dynamic sign -2.0");
        send(0, mk_n(0, 63, (22'h1 << 12) | (22'h1 << 11)), 30'h7C02, "R2 tie odd");
        send(0, mk_n(0, 63, (22'h2 << 12) | (22'h1 << 11)), 30'h7C02, "R2 tie even");
        send(0, mk_n(0, 63, (22'h2 << 12) | (22'h1 << 11) | 22'h1), 30'h7C03, "R2 above half");
        send(0, mk_n(0, 63, (22'h3 << 12) | 22'h7FF),  30'h7C03,  "R2 below half");
        send(0, mk_n(0, 63, 22'h3FFFFF),               30'h8000,  "R4 carry into exponent");
        send(0, mk_n(0, 94, 22'h3FF << 12),            30'hFBFF,  "R5 largest finite");
        send(0, mk_n(0, 95, 0),                        30'hFC00,  "R5 overflow to inf");
        send(0, mk_n(0, 94, 22'h3FFFFF),               30'hFC00,  "R5 carry overflow");
        send(0, mk_n(1, 127, 5),                       30'h1FE00, "R7 quiet nan");
        send(0, mk_n(1, 127, 0),                       30'h1FC00, "R7 negative inf");
        send(0, mk_n(0, 32, 0),                        30'h0200,  "R8 subnormal half");
        send(0, mk_n(0, 23, 0),                        30'h0001,  "R8 smallest subnormal");
        send(0, mk_n(1, 22, 0),                        30'h10000, "R8 tie to signed zero");
        send(0, mk_n(0, 22, 1),                        30'h0001,  "R8 above half rounds up");
        send(0, mk_n(0, 32, 22'h3FFFFF),               30'h0400,  "R8 round into normal");
        send(0, mk_n(1, 0, 0),                         30'h10000, "R1 negative zero");

        // instance B: 6/10 bias 31 -> 7/22 bias 63
        send(1, mk_h(0, 31, 0),                        30'h0FC00000, "R1 widen 1.0");
        send(1, mk_h(0, 31, 2),                        30'h0FC02000, "R1 widen fraction");
        send(1, mk_h(0, 0, 1),                         30'h05C00000, "R10 normalise smallest");
        send(1, mk_h(0, 0, 10'h300),                   30'h08200000, "R10 normalise 0x300");
        send(1, mk_h(1, 0, 0),                         30'h20000000, "R1 widen negative zero");
        send(1, mk_h(0, 63, 0),                        30'h1FBFFFFF, "R6 unchecked inf");
        send(1, mk_h(0, 62, 10'h3FF),                  30'h17BFF000, "R1 widen largest");

        // instance C: truncate, saturate, flush, positive-only
        send(2, mk_n(0, 63, 0),                        30'h7C00, "R1 fixed sign 1.0");
        send(2, mk_n(0, 63, (22'h1 << 12) | (22'h1 << 11)), 30'h7C01, "R3 truncate tie");
        send(2, mk_n(0, 63, 22'h3FFFFF),               30'h7FFF, "R3 truncate all ones");
        send(2, mk_n(1, 63, 0),                        30'h7C00, "R11 sign dropped");
        send(2, mk_n(0, 95, 0),                        30'hFBFF, "R6 saturate overflow");
        send(2, mk_n(1, 127, 0),                       30'hFBFF, "R6 saturate inf");
        send(2, mk_n(0, 127, 3),                       30'hFBFF, "R6 saturate nan");
        send(2, mk_n(0, 32, 22'h3FFFFF),               30'h0000, "R9 flush no round up");
        send(2, mk_n(0, 33, 0),                        30'h0400, "R9 smallest normal kept");

        idle(4);
        // R12 output holds while idle
        check("R12 hold", {12'd0, a_vld_o, a_out}, last_a);

        for (int i = 0; i < 20 && sb.size() != 0; i++) @(negedge clk);
        if (sb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R12: got %0d pending expected 0", sb.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule